// File: doc/BRIEF.md
# Memory Device Boundary-Scan Test Port

This block is the boundary-scan test access port of a synchronous memory device. A tester clocks it through TCK and steers it with TMS. Serial data enters on TDI and leaves on TDO. The port holds the sixteen-state TAP controller, a 3-bit instruction register, a 1-bit bypass stage, a 32-bit identification word and a boundary scan register of parameterised length. The boundary scan register samples the parallel I/O ring of the device.

The instruction set has three defined codes. Two of them connect the boundary scan register. The third returns the identification word. One of the boundary-scan codes also drives a control that forces every memory output driver to high impedance while that code is the active instruction. Every other code falls back to the bypass stage. The scanned-in boundary value is held in update latches that change only at the end of a data scan. Instead of a tri-state pad, TDO comes with an output-enable signal.

Top module: `mem_tap_port`

## Requirements
- R1: The instruction register is 3 bits wide. It loads the fixed pattern 001 in Capture-IR and shifts least significant bit first. A newly shifted code takes effect only on Update-IR, so the active instruction does not change while the code is being shifted in.
- R2: Code 000 selects the boundary scan register. In Capture-DR that register loads ring_i, with bit k of ring_i going to cell k, and cell 0 is the next bit out.
- R3: Code 001 selects the 32-bit identification word for capture and shift. Its fields are: bits 31:29 = 000, bits 28:24 = 01011, bits 23:18 = 000000, bits 17:12 = the WIDTH_CODE parameter, bits 11:1 = 00000110100, and bit 0 = 1.
- R4: Code 010 selects and captures the boundary scan register in the same way as code 000. hiz_force_o is high exactly while 010 is the active instruction and is low for every other code.
- R5: Codes 011 through 111 select the 1-bit bypass stage. It captures 0, so TDO returns a 0 followed by TDI delayed by one TCK.
- R6: Test-Logic-Reset sets the active instruction to 001 and drops hiz_force_o. This applies whether the state is reached by five TCK cycles with TMS high or by rst_ni going low.
- R7: Registers shift on the rising edge of TCK, with TDI entering the most significant bit. TDO changes only on the falling edge of TCK. tdo_en_o is high only in Shift-IR and Shift-DR, and tdo_o is 0 in all other states.
- R8: ring_o, the boundary update latches, changes only on Update-DR while code 000 or 010 is active. ring_o resets to 0. Scans of the identification word or the bypass stage leave it unchanged.
- R9: The boundary scan register length is set by BSR_LEN, which defaults to 89 and also supports 138.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous test reset |
| tms_i | input | 1 | Test mode select |
| tdi_i | input | 1 | Serial test data in |
| ring_i | input | BSR_LEN | Parallel I/O ring values captured by the boundary scan register |
| tdo_o | output | 1 | Serial test data out, updated on the falling edge of TCK |
| tdo_en_o | output | 1 | High while TDO carries shift data |
| hiz_force_o | output | 1 | Forces the memory output drivers to high impedance |
| ring_o | output | BSR_LEN | Boundary update latch contents |

## Verification
The bench builds the port with BSR_LEN set to 138 and WIDTH_CODE set to 110111. This exercises the longer chain and an identification word different from the default. Each data scan runs eight bits longer than the boundary register, so the whole chain length shows in the position where TDI reappears on TDO, and the full update-latch width is compared. All eight instruction codes are swept in turn. This places each high-impedance transition immediately after an instruction shift, so a change that appears too early is caught.

// File: rtl/mem_tap_pkg.sv
package mem_tap_pkg;
  localparam int IR_W = 3;
  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SHF_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SHF_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPLEZ = 3'b010;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [1:0] {SEL_BSR, SEL_ID, SEL_BYP} dr_sel_e;

  function automatic dr_sel_e decode_op(logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_SAMPLEZ: return SEL_BSR;
      OP_IDCODE:             return SEL_ID;
      default:               return SEL_BYP;
    endcase
  endfunction
endpackage

// File: rtl/mem_tap_fsm.sv
module mem_tap_fsm
  import mem_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TLR:    state_d = tms_i ? TLR    : RTI;
      RTI:    state_d = tms_i ? SEL_DR : RTI;
      SEL_DR: state_d = tms_i ? SEL_IR : CAP_DR;
      CAP_DR: state_d = tms_i ? EX1_DR : SHF_DR;
      SHF_DR: state_d = tms_i ? EX1_DR : SHF_DR;
      EX1_DR: state_d = tms_i ? UPD_DR : PAU_DR;
      PAU_DR: state_d = tms_i ? EX2_DR : PAU_DR;
      EX2_DR: state_d = tms_i ? UPD_DR : SHF_DR;
      UPD_DR: state_d = tms_i ? SEL_DR : RTI;
      SEL_IR: state_d = tms_i ? TLR    : CAP_IR;
      CAP_IR: state_d = tms_i ? EX1_IR : SHF_IR;
      SHF_IR: state_d = tms_i ? EX1_IR : SHF_IR;
      EX1_IR: state_d = tms_i ? UPD_IR : PAU_IR;
      PAU_IR: state_d = tms_i ? EX2_IR : PAU_IR;
      EX2_IR: state_d = tms_i ? UPD_IR : SHF_IR;
      UPD_IR: state_d = tms_i ? SEL_DR : RTI;
      default: state_d = TLR;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TLR;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R6
  tlr_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == TLR && tms_i) |=> (state_q == TLR));
endmodule

// File: rtl/mem_tap_ir.sv
module mem_tap_ir
  import mem_tap_pkg::*;
(
  input  logic            tck_i,
  input  logic            rst_ni,
  input  tap_state_e      state_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] op_o,
  output logic            ir_lsb_o
);
  logic [IR_W-1:0] sr_q, op_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= IR_CAPTURE;
      op_q <= OP_IDCODE;
    end else begin
      case (state_i)
        TLR:     op_q <= OP_IDCODE;
        CAP_IR:  sr_q <= IR_CAPTURE;
        SHF_IR:  sr_q <= {tdi_i, sr_q[IR_W-1:1]};
        UPD_IR:  op_q <= sr_q;
        default: ;
      endcase
    end
  end

  assign op_o     = op_q;
  assign ir_lsb_o = sr_q[0];

  // R1
  op_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !(state_i inside {UPD_IR, TLR}) |=> $stable(op_q));
endmodule

// File: rtl/mem_tap_dr.sv
module mem_tap_dr
  import mem_tap_pkg::*;
#(
  parameter int         BSR_LEN    = 89,
  parameter logic [5:0] WIDTH_CODE = 6'b010111
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  tap_state_e         state_i,
  input  dr_sel_e            sel_i,
  input  logic               tdi_i,
  input  logic [BSR_LEN-1:0] ring_i,
  output logic [BSR_LEN-1:0] ring_o,
  output logic               dr_lsb_o
);
  localparam logic [ID_W-1:0] ID_WORD =
    {3'b000, 5'b01011, 6'b000000, WIDTH_CODE, 11'b00000110100, 1'b1};

  logic               byp_q;
  logic [ID_W-1:0]    id_q;
  logic [BSR_LEN-1:0] bsr_q, upd_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q <= 1'b0;
      id_q  <= ID_WORD;
      bsr_q <= '0;
      upd_q <= '0;
    end else begin
      case (state_i)
        CAP_DR: begin
          case (sel_i)
            SEL_BSR: bsr_q <= ring_i;
            SEL_ID:  id_q  <= ID_WORD;
            default: byp_q <= 1'b0;
          endcase
        end
        SHF_DR: begin
          case (sel_i)
            SEL_BSR: bsr_q <= {tdi_i, bsr_q[BSR_LEN-1:1]};
            SEL_ID:  id_q  <= {tdi_i, id_q[ID_W-1:1]};
            default: byp_q <= tdi_i;
          endcase
        end
        UPD_DR: if (sel_i == SEL_BSR) upd_q <= bsr_q;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel_i)
      SEL_BSR: dr_lsb_o = bsr_q[0];
      SEL_ID:  dr_lsb_o = id_q[0];
      default: dr_lsb_o = byp_q;
    endcase
  end

  assign ring_o = upd_q;

  // R8
  upd_hold_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i != UPD_DR) |=> $stable(upd_q));

  // R5
  byp_zero_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_i == CAP_DR && sel_i == SEL_BYP) |=> !byp_q);
endmodule

// File: rtl/mem_tap_port.sv
module mem_tap_port
  import mem_tap_pkg::*;
#(
  parameter int         BSR_LEN    = 89,
  parameter logic [5:0] WIDTH_CODE = 6'b010111
) (
  input  logic               tck_i,
  input  logic               rst_ni,
  input  logic               tms_i,
  input  logic               tdi_i,
  input  logic [BSR_LEN-1:0] ring_i,
  output logic               tdo_o,
  output logic               tdo_en_o,
  output logic               hiz_force_o,
  output logic [BSR_LEN-1:0] ring_o
);
  tap_state_e      state;
  logic [IR_W-1:0] op;
  logic            ir_lsb, dr_lsb;
  dr_sel_e         sel;

  mem_tap_fsm u_fsm (
    .tck_i, .rst_ni, .tms_i, .state_o(state)
  );

  mem_tap_ir u_ir (
    .tck_i, .rst_ni, .state_i(state), .tdi_i, .op_o(op), .ir_lsb_o(ir_lsb)
  );

  assign sel = decode_op(op);

  mem_tap_dr #(.BSR_LEN(BSR_LEN), .WIDTH_CODE(WIDTH_CODE)) u_dr (
    .tck_i, .rst_ni, .state_i(state), .sel_i(sel), .tdi_i,
    .ring_i, .ring_o, .dr_lsb_o(dr_lsb)
  );

  // TDO retimed to falling edge
  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_o    <= 1'b0;
      tdo_en_o <= 1'b0;
    end else if (state == SHF_IR) begin
      tdo_o    <= ir_lsb;
      tdo_en_o <= 1'b1;
    end else if (state == SHF_DR) begin
      tdo_o    <= dr_lsb;
      tdo_en_o <= 1'b1;
    end else begin
      tdo_o    <= 1'b0;
      tdo_en_o <= 1'b0;
    end
  end

  assign hiz_force_o = (op == OP_SAMPLEZ);

  // R7
  tdo_window_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_en_o |-> (state inside {SHF_IR, SHF_DR}));

  // R6
  tlr_hiz_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state == TLR) |=> !hiz_force_o);

  // R4
  hiz_bsr_chk: assert property (@(posedge tck_i) disable iff (!rst_ni)
    hiz_force_o |-> (sel == SEL_BSR));
endmodule

// File: tb/mem_tap_port_test.sv
module mem_tap_port_test;
  localparam int         BSR = 138;
  localparam logic [5:0] WC  = 6'b110111;
  localparam int         NSH = BSR + 8;
  localparam logic [31:0] ID_EXP =
    {3'b000, 5'b01011, 6'b000000, WC, 11'b00000110100, 1'b1};
  // per code: {hiz, kind}; kind 0 = boundary, 1 = id, 2 = bypass
  localparam logic [2:0] TBL [8] = '{3'b000, 3'b001, 3'b100, 3'b010,
                                     3'b010, 3'b010, 3'b010, 3'b010};

  logic tck = 1'b0, rst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic [BSR-1:0] ring_in, ring_out;
  logic tdo, tdo_en, hiz;
  int checks = 0, errors = 0;
  logic [BSR-1:0] exp_ring;
  bit done = 0;

  assign ring_in = {10'h2A5, {4{32'hC3A5_1E69}}};

  always #5 tck = ~tck;

  mem_tap_port #(.BSR_LEN(BSR), .WIDTH_CODE(WC)) uut (
    .tck_i(tck), .rst_ni(rst_n), .tms_i(tms), .tdi_i(tdi), .ring_i(ring_in),
    .tdo_o(tdo), .tdo_en_o(tdo_en), .hiz_force_o(hiz), .ring_o(ring_out)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    tms = m; tdi = d;
    o = tdo;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic load_ir(input logic [2:0] code, output logic [2:0] cap,
                         output logic hiz_mid);
    logic b;
    step(1, 0, b); step(1, 0, b); step(0, 0, b); step(0, 0, b);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, code[i], b);
      cap[i] = b;
    end
    hiz_mid = hiz;
    step(1, 0, b); step(0, 0, b);
  endtask

  task automatic scan_dr(input int n, input logic [159:0] din,
                         output logic [159:0] dout, output logic [BSR-1:0] mid);
    logic b;
    dout = '0;
    step(1, 0, b); step(0, 0, b); step(0, 0, b);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i], b);
      dout[i] = b;
    end
    mid = ring_out;
    step(1, 0, b); step(0, 0, b);
  endtask

  function automatic logic [159:0] model(int n, int l, logic [159:0] cap,
                                         logic [159:0] din);
    logic [159:0] r = '0;
    for (int i = 0; i < n; i++) r[i] = (i < l) ? cap[i] : din[i-l];
    return r;
  endfunction

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] cap;
    logic hm, b, prev_hiz;
    logic [159:0] din, dout, capv;
    logic [BSR-1:0] mid;
    int l;

    // reset state
    #2;
    chk(!hiz, "R6 hiz in reset", 160'(hiz), 0);
    chk(!tdo_en && !tdo, "R7 tdo idle in reset", 160'({tdo_en, tdo}), 0);
    chk(ring_out == '0, "R8 latches reset", 160'(ring_out), 0);
    @(negedge tck); #1; rst_n = 1;
    step(0, 0, b);
    exp_ring = '0;
    prev_hiz = 0;

    // sweep of every code
    for (int c = 0; c < 8; c++) begin
      load_ir(3'(c), cap, hm);
      chk(cap == 3'b001, "R1 capture pattern", 160'(cap), 160'(3'b001));
      chk(hm == prev_hiz, "R1 no early effect", 160'(hm), 160'(prev_hiz));
      chk(hiz == TBL[c][2], "R4 hiz per code", 160'(hiz), 160'(TBL[c][2]));
      din = {5{32'h9E37_79B9}} >> c;
      case (TBL[c][1:0])
        2'd0:    begin l = BSR; capv = 160'(ring_in); end
        2'd1:    begin l = 32;  capv = 160'(ID_EXP); end
        default: begin l = 1;   capv = '0; end
      endcase
      scan_dr(NSH, din, dout, mid);
      case (TBL[c][1:0])
        2'd0:    chk(dout == model(NSH, l, capv, din), "R2 R4 R9 boundary scan",
                     dout, model(NSH, l, capv, din));
        2'd1:    chk(dout == model(NSH, l, capv, din), "R3 id scan",
                     dout, model(NSH, l, capv, din));
        default: chk(dout == model(NSH, l, capv, din), "R5 bypass scan",
                     dout, model(NSH, l, capv, din));
      endcase
      chk(mid == exp_ring, "R8 latches hold before update", 160'(mid), 160'(exp_ring));
      if (TBL[c][1:0] == 2'd0)
        for (int j = 0; j < BSR; j++) exp_ring[j] = din[NSH-BSR+j];
      chk(ring_out == exp_ring, "R8 latches after update", 160'(ring_out), 160'(exp_ring));
      chk(!tdo_en && !tdo, "R7 tdo idle", 160'({tdo_en, tdo}), 0);
      prev_hiz = TBL[c][2];
    end

    // TDO moves on falling edge only (IDCODE active after code 7? reload)
    load_ir(3'b001, cap, hm);
    step(1, 0, b); step(0, 0, b); step(0, 0, b);
    chk(tdo == 1'b1 && tdo_en, "R7 first id bit", 160'(tdo), 1);
    tms = 0;
    @(posedge tck); #1;
    chk(tdo == 1'b1, "R7 tdo held past rising edge", 160'(tdo), 1);
    @(negedge tck); #1;
    chk(tdo == 1'b0, "R7 tdo after falling edge", 160'(tdo), 0);
    step(1, 0, b); step(1, 0, b); step(0, 0, b);

    // TMS reset
    load_ir(3'b010, cap, hm);
    chk(hiz, "R4 hiz set", 160'(hiz), 1);
    for (int i = 0; i < 5; i++) step(1, 0, b);
    chk(!hiz, "R6 hiz cleared by tms reset", 160'(hiz), 0);
    step(0, 0, b);
    scan_dr(32, '0, dout, mid);
    chk(dout[31:0] == ID_EXP, "R6 id after tms reset", dout, 160'(ID_EXP));

    // async reset
    load_ir(3'b010, cap, hm);
    rst_n = 0; #1;
    chk(!hiz, "R6 hiz cleared by rst_ni", 160'(hiz), 0);
    chk(ring_out == '0, "R8 latches cleared by rst_ni", 160'(ring_out), 0);
    @(negedge tck); #1; rst_n = 1;
    step(0, 0, b);
    scan_dr(32, '0, dout, mid);
    chk(dout[31:0] == ID_EXP, "R6 id after rst_ni", dout, 160'(ID_EXP));

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule